// File: doc/BRIEF.md
# Codec Command Slot Engine

This block is the register-side engine that turns software slot writes into codec register accesses. Software first loads the data slot word and then the command slot word. The command write queues one access. The engine presents it to the codec on a request/acknowledge handshake, as a write of a 16-bit value or as a read of one 16-bit register.

When a read is acknowledged, the engine fills two receive slot registers and raises valid flags. The first holds the command word with its read bit cleared. The second holds the returned value placed at the data field position. A flag register reports transmit-empty, receive-busy and receive-valid state for both slots. A command written while an access is still outstanding waits until that access has been acknowledged.

Registers are addressed on a small register port: 0 command transmit, 1 data transmit, 2 command receive, 3 data receive, 4 flags. Any other address reads zero.

Top module: `codec_slot_if`

## Requirements
- R1: After reset the flag register reads 0x07: command-empty is bit 0, data-empty is bit 1, combined-empty is bit 2, command-busy is bit 3, data-busy is bit 4, command-valid is bit 5 and data-valid is bit 6. `codec_req_o` is low and both receive registers read 0.
- R2: A write to address 1 stores the full 20-bit word, which reads back at address 1, and clears data-empty (flag bit 1).
- R3: A write to address 0 stores the word, which reads back at address 0, and clears command-empty (flag bit 0). Combined-empty (bit 2) is 1 only while bits 0 and 1 are both 1.
- R4: When no access is outstanding, `codec_req_o` rises on the second clock edge after the command write. `codec_idx_o` is command bits 18..12, `codec_we_o` is the inverse of command bit 19, and `codec_wdata_o` is data bits 19..4. All of these hold steady until the edge on which `codec_ack_i` is seen, and `codec_req_o` then falls.
- R5: On the edge that issues an access, command-empty and data-empty (flag bits 0 and 1) are set again.
- R6: While a read access is outstanding, both busy flags (bits 3 and 4) are 1. They clear when the read is acknowledged, and they are never set for a write access.
- R7: On the acknowledge of a read, address 2 takes the issued command word with bit 19 cleared, address 3 takes `codec_rdata_i` shifted left by 4, and both valid flags (bits 5 and 6) are set.
- R8: Completion of a write access leaves both receive registers and the valid flags unchanged.
- R9: A command written while an access is outstanding is held. It is issued with the data word current at issue time, one edge after the previous acknowledge, and `codec_req_o` is low for at least one cycle in between.
- R10: A read of address 3 (with `reg_re_i` high) clears both valid flags. Reads of any other address leave them set.
- R11: Writes to addresses 2, 3 and 4 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects only) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 20 | Register write data |
| reg_rdata_o | output | 20 | Register read data (combinational on address) |
| codec_req_o | output | 1 | Access request to codec |
| codec_we_o | output | 1 | 1 = register write, 0 = register read |
| codec_idx_o | output | 7 | Codec register index |
| codec_wdata_o | output | 16 | Codec write data |
| codec_ack_i | input | 1 | Access completion from codec |
| codec_rdata_i | input | 16 | Codec read value, valid with ack |

## Verification
The bench goes after a command written while an access is still outstanding. A design that dropped it would log one request too few. A design that issued it at once would change the request fields before the acknowledge. The bench also checks that a write completion leaves the receive registers and valid flags as they were; a design that captured on every acknowledge would corrupt them. Other targets are the read echo, where a missing cleared read bit or a wrong shift shows up as a mismatch, and valid clearing, which must come only from a read of the data receive register. Writes to read-only addresses must not change anything.

// File: rtl/slot_pkg.sv
package slot_pkg;
  typedef enum logic [2:0] {
    ADDR_CMD_TX  = 3'd0,
    ADDR_DATA_TX = 3'd1,
    ADDR_CMD_RX  = 3'd2,
    ADDR_DATA_RX = 3'd3,
    ADDR_FLAGS   = 3'd4
  } slot_addr_e;

  // packed MSB first: cmd_empty lands on bit 0
  typedef struct packed {
    logic data_valid;
    logic cmd_valid;
    logic data_busy;
    logic cmd_busy;
    logic both_empty;
    logic data_empty;
    logic cmd_empty;
  } slot_flags_t;

  localparam int unsigned NUM_FLAGS = $bits(slot_flags_t);
endpackage

// File: rtl/slot_tx_regs.sv
module slot_tx_regs
  import slot_pkg::*;
#(
  parameter int unsigned SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  slot_addr_e        addr_i,
  input  logic [SLOT_W-1:0] wdata_i,
  input  logic              issue_i,
  output logic [SLOT_W-1:0] cmd_o,
  output logic [SLOT_W-1:0] data_o,
  output logic              pending_o,
  output logic              cmd_empty_o,
  output logic              data_empty_o
);
  logic cmd_wr, data_wr;
  assign cmd_wr  = we_i && (addr_i == ADDR_CMD_TX);
  assign data_wr = we_i && (addr_i == ADDR_DATA_TX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o        <= '0;
      data_o       <= '0;
      pending_o    <= 1'b0;
      cmd_empty_o  <= 1'b1;
      data_empty_o <= 1'b1;
    end else begin
      if (cmd_wr) cmd_o <= wdata_i;
      if (data_wr) data_o <= wdata_i;
      // a new command outranks the issue of the previous one
      if (cmd_wr) pending_o <= 1'b1;
      else if (issue_i) pending_o <= 1'b0;
      if (cmd_wr) cmd_empty_o <= 1'b0;
      else if (issue_i) cmd_empty_o <= 1'b1;
      if (data_wr) data_empty_o <= 1'b0;
      else if (issue_i) data_empty_o <= 1'b1;
    end
  end
endmodule

// File: rtl/slot_req_ctrl.sv
module slot_req_ctrl #(
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned DAT_W   = 16,
  parameter int unsigned IDX_LSB = 12,
  parameter int unsigned RW_BIT  = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pending_i,
  input  logic [SLOT_W-1:0] cmd_i,
  input  logic [DAT_W-1:0]  wfield_i,
  input  logic              ack_i,
  output logic              issue_o,
  output logic              issue_read_o,
  output logic              done_read_o,
  output logic              req_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DAT_W-1:0]  wdata_o,
  output logic [SLOT_W-1:0] cmd_word_o
);
  assign issue_o      = pending_i && !req_o;
  assign issue_read_o = issue_o && cmd_i[RW_BIT];
  assign done_read_o  = req_o && ack_i && !we_o;
  assign idx_o        = cmd_word_o[IDX_LSB +: IDX_W];
  assign we_o         = !cmd_word_o[RW_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o      <= 1'b0;
      wdata_o    <= '0;
      cmd_word_o <= '0;
    end else if (issue_o) begin
      req_o      <= 1'b1;
      wdata_o    <= wfield_i;
      cmd_word_o <= cmd_i;
    end else if (req_o && ack_i) begin
      req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/slot_rx_regs.sv
module slot_rx_regs #(
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned DAT_W   = 16,
  parameter int unsigned DAT_LSB = 4,
  parameter int unsigned RW_BIT  = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_read_i,
  input  logic              done_read_i,
  input  logic [SLOT_W-1:0] cmd_word_i,
  input  logic [DAT_W-1:0]  rdata_i,
  input  logic              rd_clear_i,
  output logic [SLOT_W-1:0] cmd_rx_o,
  output logic [SLOT_W-1:0] data_rx_o,
  output logic              busy_o,
  output logic              valid_o
);
  localparam logic [SLOT_W-1:0] RW_MASK = ~(SLOT_W'(1) << RW_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_rx_o  <= '0;
      data_rx_o <= '0;
      busy_o    <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      if (done_read_i) begin
        cmd_rx_o  <= cmd_word_i & RW_MASK;
        data_rx_o <= SLOT_W'(rdata_i) << DAT_LSB;
      end
      if (issue_read_i) busy_o <= 1'b1;
      else if (done_read_i) busy_o <= 1'b0;
      // a completing read wins over a same-cycle clear
      if (done_read_i) valid_o <= 1'b1;
      else if (rd_clear_i) valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/codec_slot_if.sv
module codec_slot_if
  import slot_pkg::*;
#(
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned DAT_W   = 16,
  parameter int unsigned IDX_LSB = 12,
  parameter int unsigned DAT_LSB = 4,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [SLOT_W-1:0] reg_wdata_i,
  output logic [SLOT_W-1:0] reg_rdata_o,
  output logic              codec_req_o,
  output logic              codec_we_o,
  output logic [IDX_W-1:0]  codec_idx_o,
  output logic [DAT_W-1:0]  codec_wdata_o,
  input  logic              codec_ack_i,
  input  logic [DAT_W-1:0]  codec_rdata_i
);
  localparam int unsigned RW_BIT = SLOT_W - 1;

  slot_addr_e                addr;
  logic [SLOT_W-1:0]         cmd_q, data_q, cmd_word, cmd_rx_q, data_rx_q;
  logic                      pending, issue, issue_read, done_read;
  logic                      cmd_empty, data_empty, rx_busy, rx_valid, rd_clear;
  slot_flags_t               flags;
  logic [NUM_FLAGS-1:0]      flags_q;

  assign addr     = slot_addr_e'(reg_addr_i);
  assign rd_clear = reg_re_i && (addr == ADDR_DATA_RX);

  slot_tx_regs #(.SLOT_W(SLOT_W)) u_tx (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (addr),
    .wdata_i     (reg_wdata_i),
    .issue_i     (issue),
    .cmd_o       (cmd_q),
    .data_o      (data_q),
    .pending_o   (pending),
    .cmd_empty_o (cmd_empty),
    .data_empty_o(data_empty)
  );

  slot_req_ctrl #(
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .DAT_W(DAT_W),
    .IDX_LSB(IDX_LSB), .RW_BIT(RW_BIT)
  ) u_req (
    .clk_i, .rst_ni,
    .pending_i   (pending),
    .cmd_i       (cmd_q),
    .wfield_i    (data_q[DAT_LSB +: DAT_W]),
    .ack_i       (codec_ack_i),
    .issue_o     (issue),
    .issue_read_o(issue_read),
    .done_read_o (done_read),
    .req_o       (codec_req_o),
    .we_o        (codec_we_o),
    .idx_o       (codec_idx_o),
    .wdata_o     (codec_wdata_o),
    .cmd_word_o  (cmd_word)
  );

  slot_rx_regs #(
    .SLOT_W(SLOT_W), .DAT_W(DAT_W), .DAT_LSB(DAT_LSB), .RW_BIT(RW_BIT)
  ) u_rx (
    .clk_i, .rst_ni,
    .issue_read_i(issue_read),
    .done_read_i (done_read),
    .cmd_word_i  (cmd_word),
    .rdata_i     (codec_rdata_i),
    .rd_clear_i  (rd_clear),
    .cmd_rx_o    (cmd_rx_q),
    .data_rx_o   (data_rx_q),
    .busy_o      (rx_busy),
    .valid_o     (rx_valid)
  );

  always_comb begin
    flags            = '0;
    flags.cmd_empty  = cmd_empty;
    flags.data_empty = data_empty;
    flags.both_empty = cmd_empty && data_empty;
    flags.cmd_busy   = rx_busy;
    flags.data_busy  = rx_busy;
    flags.cmd_valid  = rx_valid;
    flags.data_valid = rx_valid;
  end
  assign flags_q = flags;

  always_comb begin
    case (addr)
      ADDR_CMD_TX:  reg_rdata_o = cmd_q;
      ADDR_DATA_TX: reg_rdata_o = data_q;
      ADDR_CMD_RX:  reg_rdata_o = cmd_rx_q;
      ADDR_DATA_RX: reg_rdata_o = data_rx_q;
      ADDR_FLAGS:   reg_rdata_o = SLOT_W'(flags_q);
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/codec_slot_if_chk.sv
module codec_slot_if_chk #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DAT_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NFL    = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              codec_req_o,
  input logic              codec_we_o,
  input logic [IDX_W-1:0]  codec_idx_o,
  input logic [DAT_W-1:0]  codec_wdata_o,
  input logic              codec_ack_i,
  input logic [NFL-1:0]    flags_q
);
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codec_req_o && !codec_ack_i |=> codec_req_o && $stable(codec_idx_o)
      && $stable(codec_we_o) && $stable(codec_wdata_o));

  a_r3_cmd_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_addr_i == ADDR_W'(0)) |=> !flags_q[0]);

  a_r6_busy_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[3] || flags_q[4]) |-> codec_req_o && !codec_we_o);

  a_r7_read_ack_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codec_req_o && codec_ack_i && !codec_we_o |=> flags_q[5] && flags_q[6] && !flags_q[3]);

  a_r9_gap_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codec_req_o && codec_ack_i |=> !codec_req_o);
endmodule

bind codec_slot_if codec_slot_if_chk #(
  .IDX_W(IDX_W), .DAT_W(DAT_W), .ADDR_W(ADDR_W), .NFL(slot_pkg::NUM_FLAGS)
) u_chk (.*);

// File: tb/codec_slot_if_bench.sv
module codec_slot_if_bench;
  localparam int A_CTX = 0, A_DTX = 1, A_CRX = 2, A_DRX = 3, A_FL = 4;

  logic        clk_i = 0, rst_ni = 0;
  logic        reg_we_i = 0, reg_re_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [19:0] reg_wdata_i = 0, reg_rdata_o;
  logic        codec_req_o, codec_we_o, codec_ack_i = 0;
  logic [6:0]  codec_idx_o;
  logic [15:0] codec_wdata_o, codec_rdata_i = 0;

  codec_slot_if u_codec_slot_if (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int n_req = 0, wait_cnt = 0, ack_delay = 0;
  logic [15:0] next_rdata = 0;
  logic [6:0]  log_idx [8];
  logic        log_we  [8];
  logic [15:0] log_wd  [8];

  // codec model: acknowledge after ack_delay negedges, log the request
  always @(negedge clk_i) begin
    if (codec_ack_i) begin
      codec_ack_i = 0;
      wait_cnt = 0;
    end else if (codec_req_o) begin
      if (wait_cnt >= ack_delay) begin
        codec_ack_i = 1;
        codec_rdata_i = next_rdata;
        log_idx[n_req % 8] = codec_idx_o;
        log_we[n_req % 8]  = codec_we_o;
        log_wd[n_req % 8]  = codec_wdata_o;
        n_req++;
      end else wait_cnt++;
    end
  end

  function automatic logic [6:0]  f_idx(logic [19:0] c); return c[18:12]; endfunction
  function automatic logic        f_we(logic [19:0] c);  return !c[19]; endfunction
  function automatic logic [15:0] f_wd(logic [19:0] d);  return d[19:4]; endfunction
  function automatic logic [19:0] f_crx(logic [19:0] c); return c & 20'h7FFFF; endfunction
  function automatic logic [19:0] f_drx(logic [15:0] v); return {v, 4'h0}; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [19:0] v);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 3'(a); reg_wdata_i = v;
    @(posedge clk_i); #1;
    reg_we_i = 0;
  endtask

  task automatic peek(int a, output logic [19:0] v);
    reg_addr_i = 3'(a); #1; v = reg_rdata_o;
  endtask

  task automatic rd(int a, output logic [19:0] v);
    @(negedge clk_i);
    reg_addr_i = 3'(a); reg_re_i = 1; #1; v = reg_rdata_o;
    @(posedge clk_i); #1;
    reg_re_i = 0;
  endtask

  task automatic wait_done(int target);
    int guard = 0;
    while (!(n_req == target && !codec_req_o) && guard < 100) begin
      @(negedge clk_i); guard++;
    end
    if (guard >= 100) chk("R4 access completion", 0, 1);
  endtask

  logic [19:0] v, exp_crx = 0, exp_drx = 0;
  logic        exp_valid = 0;

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    peek(A_FL, v);  chk("R1 reset flags", v, 20'h07);
    chk("R1 reset req", codec_req_o, 0);
    peek(A_CRX, v); chk("R1 reset cmd_rx", v, 0);
    peek(A_DRX, v); chk("R1 reset data_rx", v, 0);

    for (int it = 0; it < 40; it++) begin
      logic [19:0] d, c;
      logic        is_rd;
      d = 20'($urandom);
      c = 20'($urandom);
      if (it == 0) c[19] = 1'b1;
      if (it == 1) c[19] = 1'b0;
      is_rd = c[19];
      ack_delay = int'($urandom % 5);
      next_rdata = 16'($urandom);
      wr(A_DTX, d);
      peek(A_DTX, v); chk("R2 data readback", v, d);
      peek(A_FL, v);  chk("R2 data empty clear", v[1:0], 2'b01);
      wr(A_CTX, c);
      peek(A_CTX, v); chk("R3 cmd readback", v, c);
      peek(A_FL, v);  chk("R3 empties clear", v[2:0], 3'b000);
      @(posedge clk_i); #1;
      chk("R4 req rises", codec_req_o, 1);
      peek(A_FL, v);
      chk("R5 empties set on issue", v[2:0], 3'b111);
      chk("R6 busy during access", v[4:3], is_rd ? 2'b11 : 2'b00);
      wait_done(it + 1);
      chk("R4 index", log_idx[it % 8], f_idx(c));
      chk("R4 direction", log_we[it % 8], f_we(c));
      chk("R4 write data", log_wd[it % 8], f_wd(d));
      if (is_rd) begin
        exp_crx = f_crx(c); exp_drx = f_drx(next_rdata); exp_valid = 1;
      end
      peek(A_CRX, v); chk(is_rd ? "R7 cmd echo" : "R8 cmd_rx kept", v, exp_crx);
      peek(A_DRX, v); chk(is_rd ? "R7 data shifted" : "R8 data_rx kept", v, exp_drx);
      peek(A_FL, v);
      chk(is_rd ? "R7 valid set" : "R8 valid kept", v[6:5], {2{exp_valid}});
      chk("R6 busy cleared", v[4:3], 2'b00);
      if (exp_valid && ($urandom % 2 == 1)) begin
        rd(A_CRX, v); rd(A_FL, v);
        peek(A_FL, v); chk("R10 other reads keep valid", v[6:5], 2'b11);
        rd(A_DRX, v); chk("R10 data_rx read value", v, exp_drx);
        peek(A_FL, v); chk("R10 valid cleared", v[6:5], 2'b00);
        exp_valid = 0;
      end
    end

    // R11: writes to receive and flag addresses are ignored
    wr(A_CRX, 20'hABCDE); wr(A_DRX, 20'h12345); wr(A_FL, 20'hFFFFF);
    peek(A_CRX, v); chk("R11 cmd_rx unchanged", v, exp_crx);
    peek(A_DRX, v); chk("R11 data_rx unchanged", v, exp_drx);
    peek(A_FL, v);  chk("R11 flags unchanged", v, {13'd0, {2{exp_valid}}, 5'b00111});
    chk("R11 no request", codec_req_o, 0);

    // R9: command held while a read is outstanding
    begin
      logic [19:0] d1, c1, d2, c2;
      int base;
      base = n_req;
      d1 = 20'hA5A50; c1 = 20'hC3000 | 20'h80000;
      d2 = 20'h5F0F0; c2 = 20'h2D000;
      ack_delay = 6;
      next_rdata = 16'hBEEF;
      wr(A_DTX, d1); wr(A_CTX, c1);
      @(posedge clk_i); #1;
      chk("R9 first req", codec_req_o, 1);
      wr(A_DTX, d2); wr(A_CTX, c2);
      peek(A_FL, v); chk("R9 held cmd shows not empty", v[2:0], 3'b000);
      chk("R9 first still outstanding", codec_req_o, 1);
      chk("R9 fields stable", codec_idx_o, f_idx(c1));
      ack_delay = 2;
      wait_done(base + 2);
      chk("R9 first idx", log_idx[base % 8], f_idx(c1));
      chk("R9 first data", log_wd[base % 8], f_wd(d1));
      chk("R9 second idx", log_idx[(base + 1) % 8], f_idx(c2));
      chk("R9 second dir", log_we[(base + 1) % 8], 1);
      chk("R9 second data", log_wd[(base + 1) % 8], f_wd(d2));
      peek(A_CRX, v); chk("R9 read echo kept after write", v, f_crx(c1));
      peek(A_DRX, v); chk("R9 read data kept after write", v, f_drx(16'hBEEF));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule